// File: doc/BRIEF.md
# Single-Cycle Register-Machine Core

This block is a small, non-pipelined processor core. It runs a six-instruction register-machine instruction set and retires one instruction on every clock edge. Each cycle the core reads the instruction word at the program counter. It then decodes the word, reads the two source registers and forms the result. On the next rising edge it commits the register or memory write together with the program counter update. No intermediate state is ever visible.

The instruction set has six instructions:

- load a constant into a register;
- capture the address of the current instruction into a register;
- a two-operand arithmetic or logic operation;
- a branch to a register-held target, taken when a condition register is zero;
- a register-indirect load;
- a register-indirect store.

No addressing mode adds an offset. Instruction memory and data memory sit outside the core. Both are read combinationally, and the data memory takes its write on the rising edge while the write strobe is high. A debug pair reports the address of the retiring instruction and a retire strobe, so an external reference model can follow execution.

After the asynchronous active-low reset is released, the core spends one idle cycle and then retires instructions continuously. Instruction words are 32 bits. The data path, the registers and the program counter are 16 bits wide, and there are 16 general registers.

Top module: `rm_core`

## Requirements
- R1: While `rst_n` is low, `dbg_pc` is 0 and `dbg_retire` is low. Reset clears all 16 registers to 0.
- R2: In the first cycle after reset is released, `dbg_retire` is low, `dmem_we` is low and the program counter holds at 0. From the next cycle on, `dbg_retire` is high in every cycle.
- R3: `imem_addr` and `dbg_pc` both equal the address of the instruction retiring in this cycle. Every instruction except a taken branch sets the next address to the current address plus 1, modulo 2^16.
- R4: Opcode 0 (bits 31:29) writes the 16-bit constant in bits 15:0 into the register named by bits 28:25.
- R5: Opcode 1 writes the address of the current instruction into the register named by bits 28:25.
- R6: Opcode 2 reads the registers named by bits 22:19 (A) and 18:15 (B). It writes f(A,B) modulo 2^16 into the register named by bits 28:25, where bits 24:23 select f: 0 gives A+B, 1 gives A-B, 2 gives A AND B, and 3 gives A XOR B.
- R7: Opcode 3 writes no register and no memory. If the register named by bits 22:19 holds 0, the next address is the value of the register named by bits 18:15. Otherwise the next address is the current address plus 1.
- R8: Opcode 4 drives `dmem_addr` with the register named by bits 22:19. It writes `dmem_rdata` into the register named by bits 28:25.
- R9: Opcode 5 raises `dmem_we` for its cycle, with `dmem_addr` set to the register named by bits 22:19 and `dmem_wdata` set to the register named by bits 18:15. It changes no register. `dmem_we` is never high for any other opcode.
- R10: Opcodes 6 and 7 change no register and no memory, and they advance the address by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| imem_addr | output | 16 | Instruction fetch address (program counter) |
| imem_data | input | 32 | Instruction word at imem_addr, combinational |
| dmem_addr | output | 16 | Data memory address for load and store |
| dmem_rdata | input | 16 | Data word at dmem_addr, combinational |
| dmem_wdata | output | 16 | Store data |
| dmem_we | output | 1 | Store strobe, write taken on the rising edge |
| dbg_pc | output | 16 | Address of the instruction retiring this cycle |
| dbg_retire | output | 1 | High when an instruction retires this cycle |

## Verification
The assertions assume three things about the environment:

- `rst_n` rises in step with the clock;
- `imem_data` carries a settled, known word for the whole cycle in which it is retired;
- read data arrives combinationally for the address currently driven.

The bench meets these assumptions by changing every input only on the falling edge, and by releasing reset there too. It answers `dmem_addr` from a 16-word array indexed by the low address bits. Its reference model wraps addresses the same way, so both sides agree even when a register holds a large value.

// File: rtl/rm_pkg.sv
package rm_pkg;

  localparam int OPC_W = 3;
  localparam int FN_W  = 2;

  typedef enum logic [OPC_W-1:0] {
    OPC_SETK  = 3'd0,
    OPC_GETPC = 3'd1,
    OPC_ALU   = 3'd2,
    OPC_BRZ   = 3'd3,
    OPC_LD    = 3'd4,
    OPC_ST    = 3'd5,
    OPC_RSV6  = 3'd6,
    OPC_RSV7  = 3'd7
  } opc_e;

  typedef enum logic [FN_W-1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  typedef enum logic [1:0] {
    WB_CONST = 2'd0,
    WB_PC    = 2'd1,
    WB_ALU   = 2'd2,
    WB_MEM   = 2'd3
  } wb_sel_e;

  typedef struct packed {
    logic    rf_we;
    wb_sel_e wb_sel;
    logic    mem_we;
    logic    brz;
  } ctrl_t;

endpackage

// File: rtl/rm_decode.sv
module rm_decode
  import rm_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int DATA_W = 16,
  parameter int RA_W   = 4
) (
  input  logic [INSN_W-1:0] insn,
  output ctrl_t             ctrl,
  output logic [RA_W-1:0]   rd,
  output logic [RA_W-1:0]   rs1,
  output logic [RA_W-1:0]   rs2,
  output alu_fn_e           fn,
  output logic [DATA_W-1:0] konst
);

  // Field positions follow from the widths, packed from the top down.
  localparam int OP_LSB = INSN_W - OPC_W;
  localparam int RD_LSB = OP_LSB - RA_W;
  localparam int FN_LSB = RD_LSB - FN_W;
  localparam int R1_LSB = FN_LSB - RA_W;
  localparam int R2_LSB = R1_LSB - RA_W;

  opc_e opc;

  assign opc   = opc_e'(insn[OP_LSB +: OPC_W]);
  assign rd    = insn[RD_LSB +: RA_W];
  assign fn    = alu_fn_e'(insn[FN_LSB +: FN_W]);
  assign rs1   = insn[R1_LSB +: RA_W];
  assign rs2   = insn[R2_LSB +: RA_W];
  // The constant overlaps the register fields; only opcode 0 uses it.
  assign konst = insn[DATA_W-1:0];

  always_comb begin
    ctrl.rf_we  = 1'b0;
    ctrl.wb_sel = WB_ALU;
    ctrl.mem_we = 1'b0;
    ctrl.brz    = 1'b0;
    case (opc)
      OPC_SETK: begin
        ctrl.rf_we  = 1'b1;
        ctrl.wb_sel = WB_CONST;
      end
      OPC_GETPC: begin
        ctrl.rf_we  = 1'b1;
        ctrl.wb_sel = WB_PC;
      end
      OPC_ALU: begin
        ctrl.rf_we  = 1'b1;
        ctrl.wb_sel = WB_ALU;
      end
      OPC_BRZ: begin
        ctrl.brz = 1'b1;
      end
      OPC_LD: begin
        ctrl.rf_we  = 1'b1;
        ctrl.wb_sel = WB_MEM;
      end
      OPC_ST: begin
        ctrl.mem_we = 1'b1;
      end
      default: begin
        // Reserved opcodes fall through as no-ops.
        ctrl.rf_we = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/rm_alu.sv
module rm_alu
  import rm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_fn_e           fn,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    case (fn)
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      FN_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/rm_regfile.sv
module rm_regfile #(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 16,
  parameter int RA_W    = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RA_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RA_W-1:0]   raddr_a,
  input  logic [RA_W-1:0]   raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] regs_q [REG_CNT];
  logic [DATA_W-1:0] regs_d [REG_CNT];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    logic hit;

    assign hit = we && (waddr == RA_W'(g));

    always_comb begin
      regs_d[g] = regs_q[g];
      if (hit) begin
        regs_d[g] = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else begin
        regs_q[g] <= regs_d[g];
      end
    end
  end

  assign rdata_a = regs_q[raddr_a];
  assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/rm_core.sv
module rm_core
  import rm_pkg::*;
#(
  parameter int INSN_W  = 32,
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DATA_W-1:0] imem_addr,
  input  logic [INSN_W-1:0] imem_data,
  output logic [DATA_W-1:0] dmem_addr,
  input  logic [DATA_W-1:0] dmem_rdata,
  output logic [DATA_W-1:0] dmem_wdata,
  output logic              dmem_we,
  output logic [DATA_W-1:0] dbg_pc,
  output logic              dbg_retire
);

  localparam int RA_W = $clog2(REG_CNT);

  // Run flag: low for one cycle after reset release.
  logic run_q;
  logic run_d;
  logic exec_en;

  // Program counter.
  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] pc_d;
  logic [DATA_W-1:0] pc_inc;

  // Decode outputs.
  ctrl_t             ctrl;
  logic [RA_W-1:0]   rd;
  logic [RA_W-1:0]   rs1;
  logic [RA_W-1:0]   rs2;
  alu_fn_e           fn;
  logic [DATA_W-1:0] konst;

  // Data path.
  logic [DATA_W-1:0] rf_a;
  logic [DATA_W-1:0] rf_b;
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] wb_data;
  logic              rf_we;
  logic              brz_take;

  rm_decode #(
    .INSN_W (INSN_W),
    .DATA_W (DATA_W),
    .RA_W   (RA_W)
  ) u_decode (
    .insn  (imem_data),
    .ctrl  (ctrl),
    .rd    (rd),
    .rs1   (rs1),
    .rs2   (rs2),
    .fn    (fn),
    .konst (konst)
  );

  rm_regfile #(
    .DATA_W  (DATA_W),
    .REG_CNT (REG_CNT),
    .RA_W    (RA_W)
  ) u_regfile (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (rd),
    .wdata   (wb_data),
    .raddr_a (rs1),
    .raddr_b (rs2),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  rm_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .a  (rf_a),
    .b  (rf_b),
    .fn (fn),
    .y  (alu_y)
  );

  assign exec_en = run_q;
  assign run_d   = 1'b1;

  // Write-back source select.
  always_comb begin
    case (ctrl.wb_sel)
      WB_CONST: wb_data = konst;
      WB_PC:    wb_data = pc_q;
      WB_ALU:   wb_data = alu_y;
      WB_MEM:   wb_data = dmem_rdata;
      default:  wb_data = alu_y;
    endcase
  end

  assign rf_we = exec_en && ctrl.rf_we;

  // Next program counter.
  assign pc_inc   = pc_q + DATA_W'(1);
  assign brz_take = ctrl.brz && (rf_a == '0);

  always_comb begin
    pc_d = pc_q;
    if (exec_en) begin
      pc_d = brz_take ? rf_b : pc_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      run_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      run_q <= run_d;
    end
  end

  // External memory ports.
  assign imem_addr  = pc_q;
  assign dmem_addr  = rf_a;
  assign dmem_wdata = rf_b;
  assign dmem_we    = exec_en && ctrl.mem_we;

  // Debug view.
  assign dbg_pc     = pc_q;
  assign dbg_retire = exec_en;

endmodule

// File: rtl/rm_core_chk.sv
module rm_core_chk #(
  parameter int INSN_W = 32,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [INSN_W-1:0] insn,
  input logic [DATA_W-1:0] pc,
  input logic              retire,
  input logic              mem_we,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b
);

  logic [2:0] op;

  assign op = insn[INSN_W-1 -: 3];

  // R1: reset holds the counter at zero with no retirement.
  a_r1_reset_pc_zero: assert property (@(posedge clk)
    !rst_n |-> (pc == '0 && !retire));

  // R2: no store during the idle start-up cycle.
  a_r2_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |-> !mem_we);

  // R2: the counter holds across the idle start-up cycle.
  a_r2_idle_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> (pc == $past(pc)));

  // R3: every instruction other than a branch advances the counter by one.
  a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && op != 3'd3) |=> (pc == DATA_W'($past(pc) + DATA_W'(1))));

  // R7: a branch whose condition register is zero goes to the target register.
  a_r7_branch_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && op == 3'd3 && src_a == '0) |=> (pc == $past(src_b)));

  // R7: a branch whose condition register is nonzero falls through.
  a_r7_branch_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && op == 3'd3 && src_a != '0) |=> (pc == DATA_W'($past(pc) + DATA_W'(1))));

  // R9: the store strobe only comes from a retiring store.
  a_r9_we_only_store: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (retire && op == 3'd5));

endmodule

bind rm_core rm_core_chk #(
  .INSN_W (INSN_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .insn   (imem_data),
  .pc     (dbg_pc),
  .retire (dbg_retire),
  .mem_we (dmem_we),
  .src_a  (rf_a),
  .src_b  (rf_b)
);

// File: tb/rm_core_tb.sv
module rm_core_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] imem_addr;
  logic [31:0] imem_data;
  logic [15:0] dmem_addr;
  logic [15:0] dmem_rdata;
  logic [15:0] dmem_wdata;
  logic        dmem_we;
  logic [15:0] dbg_pc;
  logic        dbg_retire;

  always #4 clk = ~clk;

  rm_core u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_rdata (dmem_rdata),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dbg_pc     (dbg_pc),
    .dbg_retire (dbg_retire)
  );

  // Bench-side data memory: 16 words, indexed by the low address bits.
  logic [15:0] dmem [16];

  assign dmem_rdata = dmem[dmem_addr[3:0]];

  always @(posedge clk) begin
    if (dmem_we) begin
      dmem[dmem_addr[3:0]] <= dmem_wdata;
    end
  end

  // Reference model state.
  logic [15:0] m_rf  [16];
  logic [15:0] m_mem [16];
  logic [15:0] m_pc;
  int total = 0;
  int bad   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [2:0] op, input logic [3:0] rd,
                                      input logic [1:0] fn, input logic [3:0] r1,
                                      input logic [3:0] r2);
    return {op, rd, fn, r1, r2, 15'h0};
  endfunction

  function automatic logic [31:0] i_setk(input logic [3:0] rd, input logic [15:0] k);
    return {3'd0, rd, 9'h0, k};
  endfunction

  function automatic logic [15:0] pat(input int i);
    case (i)
      0:       return 16'h0000;
      1:       return 16'h0001;
      2:       return 16'h0002;
      3:       return 16'h7fff;
      4:       return 16'h8000;
      5:       return 16'hffff;
      6:       return 16'h1234;
      default: return 16'ha5a5;
    endcase
  endfunction

  // Present one instruction, check the cycle, then advance the model.
  task automatic exec(input logic [31:0] insn, input string tag);
    logic [2:0]  op;
    logic [3:0]  rd;
    logic [3:0]  r1;
    logic [3:0]  r2;
    logic [1:0]  fn;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] nxt_pc;

    op = insn[31:29];
    rd = insn[28:25];
    fn = insn[24:23];
    r1 = insn[22:19];
    r2 = insn[18:15];

    @(negedge clk);
    imem_data = insn;
    #1;
    a = m_rf[r1];
    b = m_rf[r2];
    chk({tag, " R3 dbg_pc"}, 32'(dbg_pc), 32'(m_pc));
    chk({tag, " R3 imem_addr"}, 32'(imem_addr), 32'(m_pc));
    chk({tag, " R2 retire"}, 32'(dbg_retire), 32'd1);
    chk({tag, " R9 we"}, 32'(dmem_we), 32'(op == 3'd5));
    if (op == 3'd5) begin
      chk({tag, " R9 addr"}, 32'(dmem_addr), 32'(a));
      chk({tag, " R9 wdata"}, 32'(dmem_wdata), 32'(b));
    end
    if (op == 3'd4) begin
      chk({tag, " R8 addr"}, 32'(dmem_addr), 32'(a));
    end

    nxt_pc = m_pc + 16'd1;
    case (op)
      3'd0: m_rf[rd] = insn[15:0];
      3'd1: m_rf[rd] = m_pc;
      3'd2: begin
        case (fn)
          2'd0:    m_rf[rd] = a + b;
          2'd1:    m_rf[rd] = a - b;
          2'd2:    m_rf[rd] = a & b;
          default: m_rf[rd] = a ^ b;
        endcase
      end
      3'd3: if (a == 16'h0) nxt_pc = b;
      3'd4: m_rf[rd] = m_mem[a[3:0]];
      3'd5: m_mem[a[3:0]] = b;
      default: ;
    endcase
    m_pc = nxt_pc;
    @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    imem_data = 32'h0;
    for (int i = 0; i < 16; i++) begin
      dmem[i]  = 16'h0;
      m_rf[i]  = 16'h0;
      m_mem[i] = 16'h0;
    end
    m_pc = 16'h0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 pc in reset", 32'(dbg_pc), 32'd0);
    chk("R1 retire in reset", 32'(dbg_retire), 32'd0);

    // Release reset; a store presented in the idle cycle must not act.
    rst_n = 1'b1;
    imem_data = enc(3'd5, 4'd0, 2'd0, 4'd0, 4'd0);
    #1;
    chk("R2 idle retire", 32'(dbg_retire), 32'd0);
    chk("R2 idle we", 32'(dmem_we), 32'd0);
    chk("R2 idle pc", 32'(dbg_pc), 32'd0);
    @(posedge clk);

    // R1: every register reads back zero after reset.
    for (int k = 0; k < 16; k++) begin
      exec(enc(3'd5, 4'd0, 2'd0, 4'd0, 4'(k)), "R1 zero reg");
    end

    // R4: constants into each register, then read back.
    for (int k = 1; k < 16; k++) begin
      exec(i_setk(4'(k), 16'h1000 + 16'(k * 16'h0111)), "R4 setk");
      exec(enc(3'd5, 4'd0, 2'd0, 4'd0, 4'(k)), "R4 readback");
    end

    // R6: sweep operand pairs and every function.
    for (int ia = 0; ia < 8; ia++) begin
      for (int ib = 0; ib < 8; ib++) begin
        exec(i_setk(4'd1, pat(ia)), "R6 opA");
        exec(i_setk(4'd2, pat(ib)), "R6 opB");
        for (int f = 0; f < 4; f++) begin
          exec(enc(3'd2, 4'd3, 2'(f), 4'd1, 4'd2), "R6 op");
          exec(enc(3'd5, 4'd0, 2'd0, 4'd0, 4'd3), "R6 result");
        end
      end
    end

    // R5: capture the current address twice at different points.
    exec(enc(3'd1, 4'd5, 2'd0, 4'd0, 4'd0), "R5 getpc");
    exec(enc(3'd5, 4'd0, 2'd0, 4'd0, 4'd5), "R5 readback");
    exec(enc(3'd1, 4'd5, 2'd0, 4'd0, 4'd0), "R5 getpc2");
    exec(enc(3'd5, 4'd0, 2'd0, 4'd0, 4'd5), "R5 readback2");

    // R7: taken, not taken, target zero, target at the top of the space (then R3 wrap).
    exec(i_setk(4'd6, 16'h0000), "R7 cond0");
    exec(i_setk(4'd7, 16'h0040), "R7 target");
    exec(enc(3'd3, 4'd0, 2'd0, 4'd6, 4'd7), "R7 taken");
    exec(i_setk(4'd6, 16'h0005), "R7 cond1");
    exec(enc(3'd3, 4'd0, 2'd0, 4'd6, 4'd7), "R7 fallthrough");
    exec(enc(3'd3, 4'd0, 2'd0, 4'd0, 4'd0), "R7 target zero");
    exec(i_setk(4'd7, 16'hffff), "R7 top target");
    exec(enc(3'd3, 4'd0, 2'd0, 4'd0, 4'd7), "R7 taken top");
    exec(enc(3'd5, 4'd0, 2'd0, 4'd0, 4'd7), "R3 wrap");
    exec(enc(3'd5, 4'd0, 2'd0, 4'd0, 4'd6), "R7 regs kept");

    // R8/R9: fill every memory word, then load each back.
    for (int ad = 0; ad < 16; ad++) begin
      exec(i_setk(4'd9, 16'(ad)), "R9 addr");
      exec(i_setk(4'd10, 16'hbe00 + 16'(ad * 3)), "R9 data");
      exec(enc(3'd5, 4'd0, 2'd0, 4'd9, 4'd10), "R9 store");
      exec(enc(3'd5, 4'd0, 2'd0, 4'd15, 4'd9), "R9 rf unchanged");
    end
    for (int ad = 0; ad < 16; ad++) begin
      exec(i_setk(4'd9, 16'(ad)), "R8 addr");
      exec(enc(3'd4, 4'd11, 2'd0, 4'd9, 4'd0), "R8 load");
      exec(i_setk(4'd12, 16'h0000), "R8 addr0");
      exec(enc(3'd5, 4'd0, 2'd0, 4'd12, 4'd11), "R8 readback");
    end

    // R10: reserved opcodes whose other fields would name r3.
    exec(i_setk(4'd3, 16'h1111), "R10 seed");
    exec(32'hc7ffffff, "R10 op6");
    exec(32'he7ffffff, "R10 op7");
    exec(enc(3'd5, 4'd0, 2'd0, 4'd0, 4'd3), "R10 r3 kept");
    exec(enc(3'd5, 4'd0, 2'd0, 4'd0, 4'd15), "R10 r15 kept");
    exec(i_setk(4'd13, 16'h0000), "R10 addr0");
    exec(enc(3'd4, 4'd14, 2'd0, 4'd13, 4'd0), "R10 mem load");
    exec(enc(3'd5, 4'd0, 2'd0, 4'd0, 4'd14), "R10 mem kept");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule